// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Interrupts

This block controls 32 general purpose lines from a simple register bus. Software picks each line's direction, can switch a line to open-drain drive, writes output values and reads back the line state through a data register. A line set as input only shows its pad value in the data register while its input buffer is enabled. On the pad side the block drives an output vector and an output-enable vector, and it takes an input vector in.

Each pad input passes through a two-flop synchronizer. A line's edge-select bit decides whether it reports falling edges only or both edges. Detected edges set sticky event bits, which software clears by writing ones. A per-line mask picks which events reach the single combined interrupt output. Line numbering runs in reverse of bit numbering in every register.

Top module: `gpio_edge_ctl`

## Requirements
- R1: After reset, the direction, open-drain, data, event, mask and edge-select registers read 0, the input buffer enable register reads all ones, every pad_oe bit is 0 and irq is 0.
- R2: Register offsets are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge-select 0x14, input buffer enable 0x18. Line n sits in register bit 31-n in every register, and pad vector bit b belongs to register bit b, so line 0 is bit 31 and pad bit 31.
- R3: A direction bit of 1 makes the line an output with pad_oe high (unless R11 releases it); a direction bit of 0 keeps pad_oe low for that line.
- R4: Writing 1 to a bit of the event register clears it; writing 0 to a bit leaves it unchanged. Writes do not set event bits.
- R5: irq is high exactly when some line has both its event bit and its mask bit at 1.
- R6: An edge-select bit of 1 records only falling edges of that line's input; a bit of 0 records both rising and falling edges.
- R7: A pad input change that is held steady shows up in the event register after the third rising clock edge (two synchronizer stages plus the event flop).
- R8: For an input line, the data register bit returns the synchronized pad value when its input buffer enable bit is 1 and returns 0 when that bit is 0.
- R9: For an output line, the data register bit returns the last value written, whatever the pad input carries.
- R10: When an edge and a write-one-to-clear reach the same event bit in the same clock, the bit stays set.
- R11: An output line with its open-drain bit at 1 drives pad_out low with pad_oe high when its data bit is 0, and drops pad_oe when its data bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one register write per cycle it is high |
| bus_rd | input | 1 | Read strobe; bus_rdata is 0 while low |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Pad input values, indexed by register bit |
| pad_out | output | 32 | Pad output values, indexed by register bit |
| pad_oe | output | 32 | Pad output enables, indexed by register bit |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the collision of R10: a clear write has to land on exactly the clock edge where the event flop captures a new edge, three edges after the pad moved. The stimulus changes the pad on a falling clock edge, counts two rising edges, then raises the clear write so that its only rising edge is the capture edge. Both edge-select modes are exercised from a table of pad transitions with event values worked out by hand. Open-drain release and output readback are checked while the pad input carries the opposite value.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR  = 5'h00,
    OFS_ODRN = 5'h04,
    OFS_DATA = 5'h08,
    OFS_EVT  = 5'h0C,
    OFS_MASK = 5'h10,
    OFS_EDGE = 5'h14,
    OFS_IBE  = 5'h18
  } reg_ofs_e;
endpackage

// File: rtl/gpio_in_edge.sv
module gpio_in_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] fall_only_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] hit_o
);
  function automatic logic edge_pick(logic now, logic prev, logic fall_only);
    logic rise, fall;
    rise = now & ~prev;
    fall = ~now & prev;
    return fall_only ? fall : (rise | fall);
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign sync_o[i] = sync_q;
    assign hit_o[i]  = edge_pick(sync_q, prev_q, fall_only_i[i]);
  end

  // R6
  fall_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & fall_only_i & sync_o) == '0);
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] evt_q;

  function automatic logic [N-1:0] evt_next(logic [N-1:0] cur, logic [N-1:0] hit,
                                            logic we, logic [N-1:0] clr);
    logic [N-1:0] kept;
    kept = we ? (cur & ~clr) : cur;
    return kept | hit;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_next(evt_q, hit_i, clr_we_i, clr_mask_i);
  end

  assign evt_o = evt_q;

  // R4
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  // R4
  evt_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((evt_q & $past(evt_q) & ~$past(clr_mask_i)) == ($past(evt_q) & ~$past(clr_mask_i))));
  // R10
  evt_edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i != '0) |=> ((evt_q & $past(hit_i)) == $past(hit_i)));
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] odrn_i,
  input  logic [N-1:0] dat_i,
  output logic [N-1:0] pad_out_o,
  output logic [N-1:0] pad_oe_o
);
  for (genvar i = 0; i < N; i++) begin : g_drv
    always_comb begin
      if (odrn_i[i]) begin
        pad_out_o[i] = 1'b0;
        pad_oe_o[i]  = dir_i[i] & ~dat_i[i];
      end else begin
        pad_out_o[i] = dat_i[i];
        pad_oe_o[i]  = dir_i[i];
      end
    end
  end

  // R3
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & ~dir_i) == '0);
  // R11
  odrn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & odrn_i & dat_i) == '0);
  // R11
  odrn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & odrn_i & pad_out_o) == '0);
endmodule

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned    NLINES  = 32,
  parameter logic [31:0]    IBE_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic              irq
);
  localparam logic [NLINES-1:0] IBE_INIT = IBE_RST[NLINES-1:0];

  logic [NLINES-1:0] dir_q, odrn_q, dat_q, mask_q, edge_q, ibe_q;
  logic [NLINES-1:0] sync_w, hit_w, evt_w, data_view_w, irq_vec_w;
  logic              evt_clr_we;

  function automatic logic [NLINES-1:0] data_view(logic [NLINES-1:0] dir,
      logic [NLINES-1:0] dat, logic [NLINES-1:0] pin, logic [NLINES-1:0] ibe);
    return (dir & dat) | (~dir & pin & ibe);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      odrn_q <= '0;
      dat_q  <= '0;
      mask_q <= '0;
      edge_q <= '0;
      ibe_q  <= IBE_INIT;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DIR:  dir_q  <= bus_wdata;
        OFS_ODRN: odrn_q <= bus_wdata;
        OFS_DATA: dat_q  <= bus_wdata;
        OFS_MASK: mask_q <= bus_wdata;
        OFS_EDGE: edge_q <= bus_wdata;
        OFS_IBE:  ibe_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign evt_clr_we = bus_wr && (bus_addr == OFS_EVT);

  gpio_in_edge #(.N(NLINES)) u_in (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pad_in),
    .fall_only_i (edge_q),
    .sync_o      (sync_w),
    .hit_o       (hit_w)
  );

  gpio_evt_latch #(.N(NLINES)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit_w),
    .clr_we_i   (evt_clr_we),
    .clr_mask_i (bus_wdata),
    .evt_o      (evt_w)
  );

  gpio_pad_drv #(.N(NLINES)) u_pad (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_i     (dir_q),
    .odrn_i    (odrn_q),
    .dat_i     (dat_q),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe)
  );

  assign data_view_w = data_view(dir_q, dat_q, sync_w, ibe_q);
  assign irq_vec_w   = evt_w & mask_q;
  assign irq         = |irq_vec_w;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_DIR:  bus_rdata = dir_q;
        OFS_ODRN: bus_rdata = odrn_q;
        OFS_DATA: bus_rdata = data_view_w;
        OFS_EVT:  bus_rdata = evt_w;
        OFS_MASK: bus_rdata = mask_q;
        OFS_EDGE: bus_rdata = edge_q;
        OFS_IBE:  bus_rdata = ibe_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R5
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0 && evt_w != '0));
  // R8
  ibe_off_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_view_w & ~dir_q & ~ibe_q) == '0);
  // R9
  out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_view_w & dir_q) == (dat_q & dir_q));
endmodule

// File: tb/gpio_edge_ctl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_DIR = 5'h00, A_ODRN = 5'h04, A_DATA = 5'h08,
                         A_EVT = 5'h0C, A_MASK = 5'h10, A_EDGE = 5'h14, A_IBE = 5'h18;

  // {edge_select, pad_start, pad_end, expected_events}
  localparam logic [127:0] VEC [4] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_00FF},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_00F0, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_000F, 32'h0000_00F0},
    {32'h0000_FFFF, 32'h00FF_00FF, 32'hFF00_FF00, 32'hFFFF_00FF}
  };

  gpio_edge_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(5ns * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    rd(A_DIR, v);  check("R1 dir", v, 32'h0);
    rd(A_ODRN, v); check("R1 odrn", v, 32'h0);
    rd(A_EVT, v);  check("R1 evt", v, 32'h0);
    rd(A_MASK, v); check("R1 mask", v, 32'h0);
    rd(A_EDGE, v); check("R1 edge", v, 32'h0);
    rd(A_IBE, v);  check("R1 ibe", v, 32'hFFFF_FFFF);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R6 edge table walk
    foreach (VEC[k]) begin
      wr(A_EDGE, VEC[k][127:96]);
      @(negedge clk); pad_in = VEC[k][95:64];
      wait_cyc(5);
      wr(A_EVT, 32'hFFFF_FFFF);
      @(negedge clk); pad_in = VEC[k][63:32];
      wait_cyc(5);
      rd(A_EVT, v);
      check($sformatf("R6 vec%0d", k), v, VEC[k][31:0]);
    end
    @(negedge clk); pad_in = '0;
    wr(A_EDGE, 32'h0);
    wait_cyc(5);
    wr(A_EVT, 32'hFFFF_FFFF);

    // R7 latency: pad change at negedge, visible after third posedge
    @(negedge clk); pad_in = 32'h0000_0010;
    @(negedge clk); @(negedge clk);
    bus_addr = A_EVT; bus_rd = 1'b1; #1 v = bus_rdata; bus_rd = 1'b0;
    check("R7 before third edge", v, 32'h0);
    @(negedge clk);
    bus_addr = A_EVT; bus_rd = 1'b1; #1 v = bus_rdata; bus_rd = 1'b0;
    check("R7 after third edge", v, 32'h0000_0010);

    // R5 mask gating, R4 write-zero / write-one
    check("R5 masked irq", {31'h0, irq}, 32'h0);
    wr(A_MASK, 32'h0000_0010);
    check("R5 unmasked irq", {31'h0, irq}, 32'h1);
    wr(A_EVT, 32'hFFFF_FFEF);
    rd(A_EVT, v); check("R4 write zero keeps", v, 32'h0000_0010);
    wr(A_EVT, 32'h0000_0010);
    rd(A_EVT, v); check("R4 write one clears", v, 32'h0);
    check("R5 irq after clear", {31'h0, irq}, 32'h0);

    // R10 edge and clear in the same clock
    @(negedge clk); pad_in = 32'h0;
    @(negedge clk); @(negedge clk);
    bus_addr = A_EVT; bus_wdata = 32'h0000_0010; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(A_EVT, v); check("R10 edge wins", v, 32'h0000_0010);
    wr(A_EVT, 32'hFFFF_FFFF);
    wr(A_MASK, 32'h0);

    // R8 input buffer enable
    @(negedge clk); pad_in = 32'h0000_0020;
    wait_cyc(3);
    rd(A_DATA, v); check("R8 ibe on", v, 32'h0000_0020);
    wr(A_IBE, 32'h0);
    rd(A_DATA, v); check("R8 ibe off", v, 32'h0);
    wr(A_IBE, 32'hFFFF_FFFF);

    // R2 R3 R9 line 0 as output, pad driven opposite
    @(negedge clk); pad_in = 32'h0;
    wr(A_DATA, 32'h8000_0000);
    wr(A_DIR, 32'h8000_0000);
    wait_cyc(3);
    rd(A_DATA, v); check("R9 output readback", v, 32'h8000_0000);
    check("R2 line0 pad_out bit31", pad_out, 32'h8000_0000);
    check("R3 line0 pad_oe bit31", pad_oe, 32'h8000_0000);

    // R11 open drain
    wr(A_ODRN, 32'h8000_0000);
    check("R11 release on one", pad_oe, 32'h0);
    wr(A_DATA, 32'h0);
    check("R11 drive low oe", pad_oe, 32'h8000_0000);
    check("R11 drive low out", pad_out, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule